// File: doc/BRIEF.md
# Dual Bit-Addressable Parallel Port Controller

This block gives a processor two identical 8-bit parallel ports behind a small register bus. Each port is placed in one of four modes by a control word: a plain output latch, a plain input latch, a released (bidirectional placeholder) mode, or a bit-wise mode. In the bit-wise mode a direction byte sets each pin separately as an input or an output. Data writes load the port's output register. Data reads return what the port currently presents to the processor.

In bit-wise mode the port also watches its pins. It builds a monitored byte from the pin levels of its input bits and the register values of its output bits. It removes the bits excluded by a mask byte and tests the rest against one of four AND/OR, high/low conditions. When that condition goes from false to true while requests are enabled, the port raises a request. The request stays up until the processor pulses that port's acknowledge input. A fixed priority encoder picks port 0 ahead of port 1.

Top module: `pio_bitctl_top`

## Requirements
- R1: After reset every port is in input mode, its output register is 0x00, its direction byte is 0xFF, its mask is 0x00, requests are disabled, all `pin_out` bits are 1 and no request is pending.
- R2: A control write whose bit 0 is 0 loads that port's vector register. A word whose low nibble is 1111 sets the mode from bits 7:6 (00 output, 01 input, 10 bidirectional, 11 bit-wise). A word whose low nibble is 0111 is an interrupt control word: bit 7 enables requests and bits 6:5 select the condition. Any other word with bit 0 set changes nothing.
- R3: After a mode word selecting bit-wise mode, the next control write to that port is stored as the direction byte, whatever its value (1 = input pin, 0 = output pin). Control writes after that are decoded as normal words again.
- R4: An interrupt control word with bit 4 set makes the next control write to that port the mask byte (1 = bit excluded from monitoring), whatever its value. Decoding then returns to normal.
- R5: `pin_out` shows the output register in output mode and all ones in input and bidirectional modes. In bit-wise mode it shows the pin level on input bits and the output register on output bits.
- R6: A data write loads the output register in output, input and bit-wise modes. In bidirectional mode the write leaves the register unchanged.
- R7: A data read returns the output register in output mode, the input latch in input mode and 0xFF in bidirectional mode. In bit-wise mode it returns the latched pin on input bits and the output register on output bits. A control read returns the vector register.
- R8: In input and bit-wise modes the input latch takes the pin value SYNC_STAGES clock edges after the pins change.
- R9: The monitored byte is (latched pins AND direction) OR (output register AND NOT direction), with the masked bits removed. Conditions: 00 = some unmasked bit low, 01 = some unmasked bit high, 10 = every unmasked bit low, 11 = every unmasked bit high. A match can only occur in bit-wise mode.
- R10: A request is raised only when the match goes from false to true while requests are enabled. It becomes pending SYNC_STAGES+1 edges after the pin change. A condition that stays true raises no further request.
- R11: A pending request stays set until an acknowledge pulse on that port's `int_ack` bit clears it at the next edge. A new rising match on the same edge wins over the acknowledge.
- R12: `irq_sel` is one-hot on the lowest-numbered pending port (port 0 first), or zero when nothing is pending. `irq_any` is set while any request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip enable for the register bus |
| port_sel | input | PSW | Port addressed by the access |
| ctl_sel | input | 1 | 1 = control access, 0 = data access |
| wr | input | 1 | Write strobe, taken on the clock edge |
| rd | input | 1 | Read strobe, data returned in the same cycle |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, zero when no read is active |
| pin_in | input | NPORTS*DW | Pin levels, port p in bits p*DW upward |
| pin_out | output | NPORTS*DW | Pin drive, all ones means released |
| int_ack | input | NPORTS | Per-port acknowledge pulse |
| irq_pend | output | NPORTS | Pending request per port |
| irq_sel | output | NPORTS | Highest-priority pending port, one-hot |
| irq_any | output | 1 | Any request pending |

## Verification
The bench builds the block with its defaults: DW = 8, NPORTS = 2 and SYNC_STAGES = 1. Two ports make simultaneous requests reachable, so the priority encoder and the per-port acknowledges can be tested. A single latch stage fixes the pin-to-request delay at two edges, and the bench samples the outputs exactly at that point. With an 8-bit width, the mode, direction and mask bytes line up with the control-word field positions. The random phase then mixes direction, mask, condition and enable over both ports.

// File: rtl/pio_pkg.sv
package pio_pkg;

   typedef enum logic [1:0] {
      MD_OUT  = 2'b00,
      MD_IN   = 2'b01,
      MD_BIDI = 2'b10,
      MD_BITC = 2'b11
   } pio_mode_e;

   typedef enum logic [1:0] {
      EXP_WORD = 2'b00,
      EXP_DIR  = 2'b01,
      EXP_MASK = 2'b10
   } pio_expect_e;

   typedef enum logic [1:0] {
      MC_ANY_LOW  = 2'b00,
      MC_ANY_HIGH = 2'b01,
      MC_ALL_LOW  = 2'b10,
      MC_ALL_HIGH = 2'b11
   } pio_cond_e;

   localparam logic [3:0] TAG_MODE = 4'b1111;
   localparam logic [3:0] TAG_ICW  = 4'b0111;
   localparam int unsigned ICW_EN_BIT   = 7;
   localparam int unsigned ICW_MNXT_BIT = 4;

endpackage

// File: rtl/pio_port_regs.sv
module pio_port_regs
   import pio_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_ctl,
   input  logic            wr_dat,
   input  logic [DW-1:0]   wdata,
   output pio_mode_e       mode_o,
   output logic [DW-1:0]   out_o,
   output logic [DW-1:0]   dir_o,
   output logic [DW-1:0]   mask_o,
   output logic [DW-1:0]   vec_o,
   output logic            en_o,
   output pio_cond_e       cond_o
);

   pio_mode_e     mode_q;
   pio_expect_e   exp_q;
   pio_cond_e     cond_q;
   logic          en_q;
   logic [DW-1:0] out_q, dir_q, mask_q, vec_q;

   logic [3:0] tag;
   assign tag = wdata[3:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MD_IN;
         exp_q  <= EXP_WORD;
         cond_q <= MC_ANY_LOW;
         en_q   <= 1'b0;
         out_q  <= '0;
         dir_q  <= '1;
         mask_q <= '0;
         vec_q  <= '0;
      end else begin
         if (wr_dat && mode_q != MD_BIDI)
            out_q <= wdata;
         if (wr_ctl) begin
            case (exp_q)
               EXP_DIR: begin
                  dir_q <= wdata;
                  exp_q <= EXP_WORD;
               end
               EXP_MASK: begin
                  mask_q <= wdata;
                  exp_q  <= EXP_WORD;
               end
               default: begin
                  if (!wdata[0]) begin
                     vec_q <= wdata;
                  end else if (tag == TAG_MODE) begin
                     mode_q <= pio_mode_e'(wdata[7:6]);
                     if (wdata[7:6] == 2'b11)
                        exp_q <= EXP_DIR;
                  end else if (tag == TAG_ICW) begin
                     en_q   <= wdata[ICW_EN_BIT];
                     cond_q <= pio_cond_e'(wdata[6:5]);
                     if (wdata[ICW_MNXT_BIT])
                        exp_q <= EXP_MASK;
                  end
               end
            endcase
         end
      end
   end

   assign mode_o = mode_q;
   assign out_o  = out_q;
   assign dir_o  = dir_q;
   assign mask_o = mask_q;
   assign vec_o  = vec_q;
   assign en_o   = en_q;
   assign cond_o = cond_q;

   // R6: a data write in bidirectional mode leaves the output register alone
   assert_bidi_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_dat && mode_q == MD_BIDI) |=> $stable(out_q));

   // R3: the byte after the direction byte is decoded as a normal word
   assert_dir_then_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && exp_q == EXP_DIR) |=> (exp_q == EXP_WORD));

   // R4: a mask byte is followed by normal decoding
   assert_mask_then_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && exp_q == EXP_MASK) |=> (exp_q == EXP_WORD && $stable(mode_q)));

endmodule

// File: rtl/pio_pin_path.sv
module pio_pin_path
   import pio_pkg::*;
#(
   parameter int unsigned DW          = 8,
   parameter int unsigned SYNC_STAGES = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] pin_i,
   input  pio_mode_e     mode_i,
   input  logic [DW-1:0] out_i,
   input  logic [DW-1:0] dir_i,
   input  logic [DW-1:0] mask_i,
   input  logic          en_i,
   input  pio_cond_e     cond_i,
   output logic [DW-1:0] pin_o,
   output logic [DW-1:0] rd_o,
   output logic          set_o
);

   logic [DW-1:0] pin_s;
   logic [DW-1:0] latch_q;
   logic          match_q;
   logic          hit;
   logic          is_bitc, tracks;
   logic [DW-1:0] mixed, mon, care;

   assign is_bitc = (mode_i == MD_BITC);
   assign tracks  = (mode_i == MD_IN) || is_bitc;

   if (SYNC_STAGES > 1) begin : g_sync
      logic [DW-1:0] chain [SYNC_STAGES-1];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int k = 0; k < SYNC_STAGES-1; k++) chain[k] <= '0;
         end else begin
            chain[0] <= pin_i;
            for (int k = 1; k < SYNC_STAGES-1; k++) chain[k] <= chain[k-1];
         end
      end
      assign pin_s = chain[SYNC_STAGES-2];
   end else begin : g_direct
      assign pin_s = pin_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q <= '0;
         match_q <= 1'b0;
      end else begin
         if (tracks) latch_q <= pin_s;
         match_q <= is_bitc & hit;
      end
   end

   assign mixed = (latch_q & dir_i) | (out_i & ~dir_i);
   assign care  = ~mask_i;
   assign mon   = mixed & care;

   always_comb begin
      case (cond_i)
         MC_ANY_LOW:  hit = (mon != care);
         MC_ANY_HIGH: hit = (mon != '0);
         MC_ALL_LOW:  hit = (mon == '0);
         default:     hit = (mon == care);
      endcase
   end

   assign set_o = is_bitc & hit & ~match_q & en_i;

   always_comb begin
      case (mode_i)
         MD_OUT:  pin_o = out_i;
         MD_BITC: pin_o = (pin_i & dir_i) | (out_i & ~dir_i);
         default: pin_o = '1;
      endcase
   end

   always_comb begin
      case (mode_i)
         MD_OUT:  rd_o = out_i;
         MD_IN:   rd_o = latch_q;
         MD_BITC: rd_o = mixed;
         default: rd_o = '1;
      endcase
   end

   // R10: a rising match lasts a single cycle, the condition is edge-triggered
   assert_single_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_o |=> !set_o);

   // R5: released pins outside the output and bit-wise modes
   assert_released_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MD_IN || mode_i == MD_BIDI) |-> (pin_o == '1));

endmodule

// File: rtl/pio_irq_arb.sv
module pio_irq_arb #(
   parameter int unsigned NPORTS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPORTS-1:0] set_i,
   input  logic [NPORTS-1:0] ack_i,
   output logic [NPORTS-1:0] pend_o,
   output logic [NPORTS-1:0] sel_o,
   output logic              any_o
);

   logic [NPORTS-1:0] pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= set_i | (pend_q & ~ack_i);
   end

   always_comb begin
      logic found;
      found = 1'b0;
      sel_o = '0;
      for (int i = 0; i < NPORTS; i++) begin
         if (pend_q[i] && !found) begin
            sel_o[i] = 1'b1;
            found    = 1'b1;
         end
      end
   end

   assign pend_o = pend_q;
   assign any_o  = |pend_q;

   // R12: at most one port selected
   assert_sel_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_o));

   for (genvar i = 0; i < NPORTS; i++) begin : g_chk
      // R11: an acknowledge without a new request clears the pending bit
      assert_ack_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_i[i] && !set_i[i]) |=> !pend_q[i]);
      // R10: a pending bit only rises after a qualified rising match
      assert_pend_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend_q[i]) |-> $past(set_i[i]));
   end

endmodule

// File: rtl/pio_bitctl_top.sv
module pio_bitctl_top
   import pio_pkg::*;
#(
   parameter int unsigned DW          = 8,
   parameter int unsigned NPORTS      = 2,
   parameter int unsigned SYNC_STAGES = 1,
   localparam int unsigned PSW = (NPORTS > 1) ? $clog2(NPORTS) : 1,
   localparam int unsigned PW  = NPORTS * DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic [PSW-1:0]    port_sel,
   input  logic              ctl_sel,
   input  logic              wr,
   input  logic              rd,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   input  logic [PW-1:0]     pin_in,
   output logic [PW-1:0]     pin_out,
   input  logic [NPORTS-1:0] int_ack,
   output logic [NPORTS-1:0] irq_pend,
   output logic [NPORTS-1:0] irq_sel,
   output logic              irq_any
);

   if (DW < 8) begin : g_bad_dw
      $error("DW must be at least 8 to hold a control word");
   end
   if (NPORTS < 1) begin : g_bad_np
      $error("NPORTS must be at least 1");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   logic [DW-1:0]     vec_w [NPORTS];
   logic [DW-1:0]     rdp_w [NPORTS];
   logic [NPORTS-1:0] set_w;

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      pio_mode_e     mode;
      pio_cond_e     cond;
      logic          en;
      logic [DW-1:0] outr, dir, mask;
      logic          hit_sel;

      assign hit_sel = cs && wr && (port_sel == PSW'(p));

      pio_port_regs #(.DW(DW)) u_regs (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_ctl (hit_sel && ctl_sel),
         .wr_dat (hit_sel && !ctl_sel),
         .wdata  (wdata),
         .mode_o (mode),
         .out_o  (outr),
         .dir_o  (dir),
         .mask_o (mask),
         .vec_o  (vec_w[p]),
         .en_o   (en),
         .cond_o (cond)
      );

      pio_pin_path #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_pins (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_i  (pin_in[p*DW +: DW]),
         .mode_i (mode),
         .out_i  (outr),
         .dir_i  (dir),
         .mask_i (mask),
         .en_i   (en),
         .cond_i (cond),
         .pin_o  (pin_out[p*DW +: DW]),
         .rd_o   (rdp_w[p]),
         .set_o  (set_w[p])
      );
   end

   always_comb begin
      rdata = '0;
      if (cs && rd) begin
         for (int p = 0; p < NPORTS; p++) begin
            if (port_sel == PSW'(p))
               rdata = ctl_sel ? vec_w[p] : rdp_w[p];
         end
      end
   end

   pio_irq_arb #(.NPORTS(NPORTS)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_w),
      .ack_i  (int_ack),
      .pend_o (irq_pend),
      .sel_o  (irq_sel),
      .any_o  (irq_any)
   );

   // R1: nothing pending while reset is applied
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (irq_pend == '0));

endmodule

// File: tb/sim_pio_bitctl_top.sv
module sim_pio_bitctl_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs = 1'b0, ctl_sel = 1'b0, wr = 1'b0, rd = 1'b0;
   logic [0:0]  port_sel = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [15:0] pin_in = '0;
   logic [15:0] pin_out;
   logic [1:0]  int_ack = '0;
   logic [1:0]  irq_pend, irq_sel;
   logic        irq_any;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   pio_bitctl_top u0 (
      .clk(clk), .rst_n(rst_n), .cs(cs), .port_sel(port_sel), .ctl_sel(ctl_sel),
      .wr(wr), .rd(rd), .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
      .pin_out(pin_out), .int_ack(int_ack), .irq_pend(irq_pend),
      .irq_sel(irq_sel), .irq_any(irq_any)
   );

   // bench model
   logic [1:0] m_mode [2];
   logic [1:0] m_cond [2];
   logic [7:0] m_out [2], m_dir [2], m_mask [2], m_vec [2];
   logic       m_en [2], m_prev [2], m_pend [2];

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pins(int p);
      return pin_in[p*8 +: 8];
   endfunction

   function automatic logic [7:0] f_pin(int p);
      case (m_mode[p])
         2'b00:   return m_out[p];
         2'b11:   return (pins(p) & m_dir[p]) | (m_out[p] & ~m_dir[p]);
         default: return 8'hFF;
      endcase
   endfunction

   function automatic logic [7:0] f_rd(int p);
      case (m_mode[p])
         2'b00:   return m_out[p];
         2'b01:   return pins(p);
         2'b11:   return (pins(p) & m_dir[p]) | (m_out[p] & ~m_dir[p]);
         default: return 8'hFF;
      endcase
   endfunction

   function automatic logic f_match(int p);
      logic [7:0] v, c;
      if (m_mode[p] != 2'b11) return 1'b0;
      c = ~m_mask[p];
      v = ((pins(p) & m_dir[p]) | (m_out[p] & ~m_dir[p])) & c;
      case (m_cond[p])
         2'b00:   return v != c;
         2'b01:   return v != 8'h00;
         2'b10:   return v == 8'h00;
         default: return v == c;
      endcase
   endfunction

   task automatic model_step();
      for (int p = 0; p < 2; p++) begin
         logic m;
         m = f_match(p);
         if (m && !m_prev[p] && m_en[p]) m_pend[p] = 1'b1;
         m_prev[p] = m;
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic bus_wr(int p, bit ctl, logic [7:0] d);
      @(negedge clk);
      cs = 1; wr = 1; ctl_sel = ctl; port_sel = 1'(p); wdata = d;
      @(negedge clk);
      cs = 0; wr = 0;
   endtask

   task automatic bus_rd(int p, bit ctl, output logic [7:0] d);
      @(negedge clk);
      cs = 1; rd = 1; ctl_sel = ctl; port_sel = 1'(p);
      #2 d = rdata;
      cs = 0; rd = 0;
   endtask

   task automatic set_pins(int p, logic [7:0] v);
      @(negedge clk);
      pin_in[p*8 +: 8] = v;
   endtask

   task automatic ack(int p);
      @(negedge clk);
      int_ack[p] = 1'b1;
      @(negedge clk);
      int_ack[p] = 1'b0;
      m_pend[p] = 1'b0;
   endtask

   task automatic check_irq(string req);
      chk(req, {14'd0, irq_pend}, {14'd0, m_pend[1], m_pend[0]});
   endtask

   // bit-wise mode setup that leaves the port with no stale request
   task automatic cfg(int p, logic [7:0] dir, logic [1:0] cond, logic [7:0] mask, bit en);
      bus_wr(p, 1, 8'hCF);
      bus_wr(p, 1, dir);
      bus_wr(p, 1, {1'b0, cond, 1'b1, 4'b0111});
      bus_wr(p, 1, mask);
      m_mode[p] = 2'b11; m_dir[p] = dir; m_cond[p] = cond; m_mask[p] = mask; m_en[p] = 1'b0;
      wait_cyc(3);
      ack(p);
      bus_wr(p, 1, {en, cond, 1'b0, 4'b0111});
      m_en[p] = en;
      wait_cyc(3);
      m_prev[p] = f_match(p);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'd4711));
      for (int p = 0; p < 2; p++) begin
         m_mode[p] = 2'b01; m_cond[p] = 0; m_out[p] = 0; m_dir[p] = 8'hFF;
         m_mask[p] = 0; m_vec[p] = 0; m_en[p] = 0; m_prev[p] = 0; m_pend[p] = 0;
      end
      pin_in = 16'hC35A;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      wait_cyc(2);
      // R1 reset state
      chk("R1 pin_out", pin_out, 16'hFFFF);
      chk("R1 irq_pend", {14'd0, irq_pend}, 16'd0);
      chk("R1 irq_any", {15'd0, irq_any}, 16'd0);
      bus_rd(0, 0, d); chk("R1/R8 read A input", {8'd0, d}, 16'h005A);
      bus_rd(1, 0, d); chk("R1/R8 read B input", {8'd0, d}, 16'h00C3);

      // R2/R5 output mode
      bus_wr(0, 1, 8'h0F); m_mode[0] = 2'b00;
      bus_wr(0, 0, 8'h3C); m_out[0] = 8'h3C;
      wait_cyc(1);
      chk("R5 output mode A", pin_out, 16'hFF3C);
      bus_rd(0, 0, d); chk("R7 read output mode", {8'd0, d}, 16'h003C);

      // R6 write in input mode is stored
      bus_wr(1, 0, 8'h96); m_out[1] = 8'h96;
      wait_cyc(1);
      chk("R5 input mode released", pin_out[15:8], 16'h00FF);
      bus_wr(1, 1, 8'h0F); m_mode[1] = 2'b00;
      wait_cyc(1);
      chk("R6 write in input mode", pin_out[15:8], 16'h0096);

      // R6/R7 bidirectional mode
      bus_wr(0, 1, 8'h8F); m_mode[0] = 2'b10;
      wait_cyc(1);
      chk("R5 bidi released", pin_out[7:0], 16'h00FF);
      bus_wr(0, 0, 8'h11);
      bus_rd(0, 0, d); chk("R7 read bidi", {8'd0, d}, 16'h00FF);
      bus_wr(0, 1, 8'h0F); m_mode[0] = 2'b00;
      wait_cyc(1);
      chk("R6 bidi write ignored", pin_out[7:0], 16'h003C);

      // R2 vector and ignored words
      bus_wr(0, 1, 8'hA6); m_vec[0] = 8'hA6;
      bus_rd(0, 1, d); chk("R2/R7 vector read", {8'd0, d}, 16'h00A6);
      bus_wr(0, 1, 8'h03);
      wait_cyc(1);
      bus_rd(0, 1, d); chk("R2 ignored word vector", {8'd0, d}, 16'h00A6);
      chk("R2 ignored word mode", pin_out[7:0], 16'h003C);

      // R8 input latch timing
      bus_wr(1, 1, 8'h4F); m_mode[1] = 2'b01;
      set_pins(1, 8'h71);
      wait_cyc(2);
      bus_rd(1, 0, d); chk("R8 latch follows", {8'd0, d}, 16'h0071);
      set_pins(1, 8'h0E);
      bus_rd(1, 0, d); chk("R8 one edge latency", {8'd0, d}, 16'h000E);

      // R3 direction byte that looks like a mode word; R4 mask byte
      set_pins(0, 8'hA5);
      cfg(0, 8'h0F, 2'b01, 8'hF0, 1'b1);
      chk("R3/R5 bitwise pins", pin_out[7:0], 16'h0035);
      bus_rd(0, 0, d); chk("R3/R7 bitwise read", {8'd0, d}, 16'h0035);
      check_irq("R10 no request at setup");

      // R9/R10 any-high on low nibble with exact latency
      set_pins(0, 8'hA0);
      wait_cyc(3); model_step(); check_irq("R9 no match");
      set_pins(0, 8'hA1);
      #1 wait_cyc(1);
      chk("R10 not yet pending", {15'd0, irq_pend[0]}, 16'd0);
      wait_cyc(1);
      chk("R10 pending after two edges", {15'd0, irq_pend[0]}, 16'd1);
      chk("R12 sel A", {14'd0, irq_sel}, 16'd1);
      model_step();
      ack(0); wait_cyc(3);
      check_irq("R10/R11 held match no repeat");
      set_pins(0, 8'hA0); wait_cyc(3); model_step();
      set_pins(0, 8'hA4); wait_cyc(3); model_step();
      check_irq("R10 second rise");
      ack(0); wait_cyc(1);
      check_irq("R11 ack clears");

      // R10 disabled
      cfg(0, 8'h0F, 2'b01, 8'hF0, 1'b0);
      set_pins(0, 8'hA0); wait_cyc(3); model_step();
      set_pins(0, 8'hA3); wait_cyc(3); model_step();
      check_irq("R10 disabled no request");

      // R9 all bits masked
      cfg(0, 8'hFF, 2'b10, 8'hFF, 1'b1);
      set_pins(0, 8'h00); wait_cyc(3); model_step();
      set_pins(0, 8'hFF); wait_cyc(3); model_step();
      check_irq("R9 all masked all-low");
      // R9 all-high on upper nibble
      cfg(0, 8'hFF, 2'b11, 8'h0F, 1'b1);
      set_pins(0, 8'h7F); wait_cyc(3); model_step();
      check_irq("R9 all-high not met");
      set_pins(0, 8'hF0); wait_cyc(3); model_step();
      check_irq("R9 all-high met");
      ack(0);

      // R12 simultaneous requests
      set_pins(1, 8'hFF);
      cfg(1, 8'hFF, 2'b00, 8'h00, 1'b1);
      set_pins(0, 8'h00); wait_cyc(3); model_step();
      @(negedge clk); pin_in = 16'hFEF0;
      wait_cyc(3); model_step();
      check_irq("R12 both pending");
      chk("R12 sel port 0 first", {14'd0, irq_sel}, 16'd1);
      ack(0); wait_cyc(1);
      chk("R12 sel port 1", {14'd0, irq_sel}, 16'd2);
      chk("R12 any", {15'd0, irq_any}, 16'd1);
      ack(1); wait_cyc(1);
      chk("R12 none", {14'd0, irq_sel, irq_any}, 16'd0);

      // random phase
      for (int it = 0; it < 300; it++) begin
         int p;
         p = $urandom % 2;
         if (it % 25 == 0)
            cfg(p, 8'($urandom), 2'($urandom), 8'($urandom), 1'($urandom % 4 != 0));
         if ($urandom % 4 == 0) begin
            logic [7:0] v;
            v = 8'($urandom);
            bus_wr(p, 0, v); m_out[p] = v;
            wait_cyc(3); model_step();
            check_irq("R9/R10 random data write");
         end
         set_pins(p, 8'($urandom));
         wait_cyc(3); model_step();
         check_irq("R9/R10 random pins");
         chk("R5 random pin_out", {8'd0, pin_out[p*8 +: 8]}, {8'd0, f_pin(p)});
         bus_rd(p, 0, d); chk("R7 random read", {8'd0, d}, {8'd0, f_rd(p)});
         if (m_pend[p] && ($urandom % 2 == 0)) begin
            ack(p); wait_cyc(1);
            check_irq("R11 random ack");
         end
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule